// File: doc/BRIEF.md
# Post-Reset Configuration Strap Sensor and Lock Sequencer

This controller wakes when reset is released and reads three mode-select codes: clocking role, input serial format and output serial format. Each code arrives as a digital value that is already resolved. The controller samples these codes at evenly spaced points across a timed sensing window. It captures the configuration only when the last two samples of every code agree. If any code changed between those two samples, the whole window starts again. Once captured, the configuration stays frozen until the next reset.

While sensing runs, the serial audio output is held muted and an unlock flag is held high. After capture, both are released only when every monitored clock has proven stable. A clock is stable when it has shown activity in a set number of consecutive monitoring windows. If any clock later stops, mute and unlock return at once. When the clocks come back, the block locks again without sensing the codes a second time. Only a new reset starts sensing over.

The block has no data stream, so it has no valid/ready interface. All of its pins are plain level controls and status signals.

Top module: `strap_lock_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `unlock` and `mute` are 1, `cfg_valid` is 0 and all three configuration outputs are 0.
- R2: While the sensing window runs, `unlock` and `mute` stay 1, even when every clock is active.
- R3: After reset is released, the block samples the codes every `SENSE_CYC/SAMPLES` cycles. The window is `WIN = (SENSE_CYC/SAMPLES)*SAMPLES` cycles long; with the defaults it is 500 cycles (4 µs at 125 MHz). If the last two samples of all three codes are equal, the codes are latched on the edge that ends the window, which is edge 1+WIN after release. `cfg_valid` rises on that same edge.
- R4: If any code changes between the second-to-last sample and the final sample, nothing is latched. A fresh window of WIN cycles starts, and its result is latched at edge 1+2·WIN.
- R5: Once `cfg_valid` is 1, it stays 1 and the configuration outputs do not change, whatever the code inputs do, until the next reset.
- R6: A clock counts as active in a monitoring window of `ACT_TIMEOUT` cycles if its activity strobe was 1 on at least one cycle of that window. `unlock` and `mute` fall only when the configuration is latched and `STABLE_WIN` consecutive windows each showed every clock active. With the clocks already stable, they fall one edge after `cfg_valid` rises.
- R7: If any clock shows no activity for a whole monitoring window after lock, `unlock` and `mute` return to 1 within two windows. The latched configuration and `cfg_valid` are kept.
- R8: After a loss, the block locks again once the clocks are stable again. It never locks before `STABLE_WIN` full windows with all clocks active have passed.
- R9: `mute` always equals `unlock`.
- R10: A new reset clears the configuration, and the next sensing window captures the codes present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_code | input | CODE_W | Resolved clocking-role select code |
| ifmt_code | input | CODE_W | Resolved input-format select code |
| ofmt_code | input | CODE_W | Resolved output-format select code |
| clk_act | input | NUM_CLK | Per-clock activity strobes, synchronous to `clk` |
| cfg_role | output | CODE_W | Latched clocking role |
| cfg_ifmt | output | CODE_W | Latched input format |
| cfg_ofmt | output | CODE_W | Latched output format |
| cfg_valid | output | 1 | Configuration has been captured |
| mute | output | 1 | Serial audio output muted |
| unlock | output | 1 | Output not yet valid |

## Verification
Four properties are checked on every cycle:
- `mute` and `unlock` stay high whenever no configuration is held.
- The configuration and `cfg_valid` never change once captured.
- Every lock coincides with the clock monitor reporting stability.
- Every relock-loss coincides with that report dropping.

Some behaviours depend on exact timing, and only the bench scenarios show them:
- The exact edge on which codes are latched.
- The restart after the final two samples disagree.
- The latency to lock with clocks absent and then restored.
- The loss and recovery timing.
- Recapture after a second reset.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    ST_RESET    = 2'd0,
    ST_SENSE    = 2'd1,
    ST_WAIT_CLK = 2'd2,
    ST_LOCKED   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/strap_sampler.sv
// Runs the timed sensing window: samples the packed codes at evenly spaced
// points and flags, on the final cycle, whether the final two samples agree.
module strap_sampler #(
  parameter int BUS_W     = 9,
  parameter int SENSE_CYC = 500,
  parameter int SAMPLES   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [BUS_W-1:0] codes,
  output logic             win_end,
  output logic             agree
);
  localparam int SP   = SENSE_CYC / SAMPLES;
  localparam int WIN  = SP * SAMPLES;
  localparam int CW   = $clog2(WIN);
  localparam int PW   = (SP > 1) ? $clog2(SP) : 1;

  logic [CW-1:0]    cnt;
  logic [PW-1:0]    phase;
  logic [BUS_W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      phase <= '0;
      if (!rst_n) prev <= '0;
    end else begin
      cnt <= win_end ? '0 : cnt + 1'b1;
      if (phase == PW'(SP - 1)) begin
        phase <= '0;
        prev  <= codes;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // The final sample is the live code on the last cycle; prev holds the one before.
  assign win_end = run && (cnt == CW'(WIN - 1));
  assign agree   = (codes == prev);
endmodule

// File: rtl/clk_activity_mon.sv
// Counts consecutive fixed-length windows in which every clock showed activity.
module clk_activity_mon #(
  parameter int NUM_CLK     = 2,
  parameter int ACT_TIMEOUT = 32,
  parameter int STABLE_WIN  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLK-1:0] act,
  output logic               stable
);
  localparam int TW = $clog2(ACT_TIMEOUT);
  localparam int GW = $clog2(STABLE_WIN + 1);

  logic [TW-1:0]      win_cnt;
  logic [GW-1:0]      good_cnt;
  logic [NUM_CLK-1:0] seen;
  logic               win_last;

  assign win_last = (win_cnt == TW'(ACT_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) win_cnt <= '0;
    else        win_cnt <= win_last ? '0 : win_cnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_seen
    always_ff @(posedge clk) begin
      if (!rst_n || win_last) seen[i] <= 1'b0;
      else if (act[i])        seen[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_cnt <= '0;
    end else if (win_last) begin
      if (&(seen | act)) begin
        if (good_cnt != GW'(STABLE_WIN)) good_cnt <= good_cnt + 1'b1;
      end else begin
        good_cnt <= '0;
      end
    end
  end

  assign stable = (good_cnt == GW'(STABLE_WIN));
endmodule

// File: rtl/strap_lock_seq.sv
module strap_lock_seq
  import strap_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int NUM_CLK     = 2,
  parameter int SENSE_CYC   = 500,
  parameter int SAMPLES     = 4,
  parameter int ACT_TIMEOUT = 32,
  parameter int STABLE_WIN  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  role_code,
  input  logic [CODE_W-1:0]  ifmt_code,
  input  logic [CODE_W-1:0]  ofmt_code,
  input  logic [NUM_CLK-1:0] clk_act,
  output logic [CODE_W-1:0]  cfg_role,
  output logic [CODE_W-1:0]  cfg_ifmt,
  output logic [CODE_W-1:0]  cfg_ofmt,
  output logic               cfg_valid,
  output logic               mute,
  output logic               unlock
);
  localparam int BUS_W = 3 * CODE_W;

  seq_state_t       state, state_nx;
  logic [BUS_W-1:0] code_bus;
  logic             win_end, agree, mon_stable, capture;

  assign code_bus = {role_code, ifmt_code, ofmt_code};

  strap_sampler #(
    .BUS_W(BUS_W), .SENSE_CYC(SENSE_CYC), .SAMPLES(SAMPLES)
  ) u_sampler (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SENSE),
    .codes(code_bus), .win_end(win_end), .agree(agree)
  );

  clk_activity_mon #(
    .NUM_CLK(NUM_CLK), .ACT_TIMEOUT(ACT_TIMEOUT), .STABLE_WIN(STABLE_WIN)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .act(clk_act), .stable(mon_stable)
  );

  assign capture = win_end && agree;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RESET:    state_nx = ST_SENSE;
      ST_SENSE:    if (capture) state_nx = ST_WAIT_CLK;
      ST_WAIT_CLK: if (mon_stable) state_nx = ST_LOCKED;
      ST_LOCKED:   if (!mon_stable) state_nx = ST_WAIT_CLK;
      default:     state_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RESET;
      cfg_role  <= '0;
      cfg_ifmt  <= '0;
      cfg_ofmt  <= '0;
      cfg_valid <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_SENSE && capture) begin
        cfg_role  <= role_code;
        cfg_ifmt  <= ifmt_code;
        cfg_ofmt  <= ofmt_code;
        cfg_valid <= 1'b1;
      end
    end
  end

  assign unlock = (state != ST_LOCKED);
  assign mute   = unlock;
endmodule

// File: rtl/strap_lock_seq_chk.sv
module strap_lock_seq_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] cfg_role,
  input logic [CODE_W-1:0] cfg_ifmt,
  input logic [CODE_W-1:0] cfg_ofmt,
  input logic              cfg_valid,
  input logic              mute,
  input logic              unlock,
  input logic              mon_stable
);
  AST_MUTED_UNTIL_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (unlock && mute)); // R2

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> (cfg_valid && $stable(cfg_role) && $stable(cfg_ifmt) && $stable(cfg_ofmt))); // R5

  AST_LOCK_NEEDS_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlock) |-> mon_stable); // R6

  AST_LOSS_FROM_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(unlock) && cfg_valid && $past(cfg_valid)) |-> !mon_stable); // R7
endmodule

bind strap_lock_seq strap_lock_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_role(cfg_role), .cfg_ifmt(cfg_ifmt),
  .cfg_ofmt(cfg_ofmt), .cfg_valid(cfg_valid), .mute(mute), .unlock(unlock),
  .mon_stable(mon_stable)
);

// File: tb/strap_lock_seq_bench.sv
`timescale 1ns/1ps
module strap_lock_seq_bench;
  localparam int CW  = 3;
  localparam int WIN = 500;
  localparam int TMO = 32;
  localparam int SW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] role_code = '0, ifmt_code = '0, ofmt_code = '0;
  logic [1:0] clk_act = '0;
  logic [1:0] clk_en = 2'b11;
  logic [CW-1:0] cfg_role, cfg_ifmt, cfg_ofmt;
  logic cfg_valid, mute, unlock;
  int n_chk = 0, n_bad = 0, pc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    pc <= pc + 1;
    clk_act[0] <= clk_en[0] && (pc % 4 == 0);
    clk_act[1] <= clk_en[1] && (pc % 4 == 2);
  end

  strap_lock_seq u_strap_lock_seq (
    .clk(clk), .rst_n(rst_n), .role_code(role_code), .ifmt_code(ifmt_code),
    .ofmt_code(ofmt_code), .clk_act(clk_act), .cfg_role(cfg_role),
    .cfg_ifmt(cfg_ifmt), .cfg_ofmt(cfg_ofmt), .cfg_valid(cfg_valid),
    .mute(mute), .unlock(unlock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [CW-1:0] r, input logic [CW-1:0] i, input logic [CW-1:0] o);
    @(negedge clk);
    rst_n = 1'b0;
    role_code = r; ifmt_code = i; ofmt_code = o;
    step(3);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] cfg_now();
    return {23'd0, cfg_role, cfg_ifmt, cfg_ofmt};
  endfunction

  task automatic t_reset_and_capture();
    do_reset(3'd1, 3'd2, 3'd5);
    chk("R1 unlock in reset", unlock, 1);
    chk("R1 cfg_valid in reset", cfg_valid, 0);
    chk("R1 cfg in reset", cfg_now(), 0);
    step(1);
    chk("R1 mute first cycle", mute, 1);
    step(WIN - 1);
    chk("R3 not yet valid at edge WIN", cfg_valid, 0);
    chk("R2 unlock during sense", unlock, 1);
    step(1);
    chk("R3 valid at edge 1+WIN", cfg_valid, 1);
    chk("R3 captured codes", cfg_now(), {23'd0, 3'd1, 3'd2, 3'd5});
    chk("R2 still unlocked at capture edge", unlock, 1);
    step(1);
    chk("R6 unlock falls next edge", unlock, 0);
    chk("R9 mute follows unlock", mute, 0);
  endtask

  task automatic t_frozen();
    role_code = 3'd7; ifmt_code = 3'd0; ofmt_code = 3'd3;
    step(300);
    chk("R5 cfg ignores code changes", cfg_now(), {23'd0, 3'd1, 3'd2, 3'd5});
    chk("R5 stays locked", unlock, 0);
  endtask

  task automatic t_restart();
    do_reset(3'd4, 3'd4, 3'd4);
    step(450);
    role_code = 3'd6; ifmt_code = 3'd1; ofmt_code = 3'd2;
    step(WIN + 1 - 450);
    chk("R4 no capture on disagreement", cfg_valid, 0);
    step(WIN - 1);
    chk("R4 not valid before second window end", cfg_valid, 0);
    chk("R2 unlocked through restart", unlock, 1);
    step(1);
    chk("R4 valid at edge 1+2*WIN", cfg_valid, 1);
    chk("R4 new window codes", cfg_now(), {23'd0, 3'd6, 3'd1, 3'd2});
  endtask

  task automatic t_loss_recover();
    step(2);
    chk("R6 locked before loss", unlock, 0);
    clk_en = 2'b01;
    step(2 * TMO + 4);
    chk("R7 unlock after loss", unlock, 1);
    chk("R9 mute after loss", mute, 1);
    chk("R7 cfg kept", cfg_now(), {23'd0, 3'd6, 3'd1, 3'd2});
    chk("R7 cfg_valid kept", cfg_valid, 1);
    clk_en = 2'b11;
    step((SW - 1) * TMO - 6);
    chk("R8 no early relock", unlock, 1);
    step(2 * TMO + 12);
    chk("R8 relocked", unlock, 0);
    chk("R8 cfg unchanged", cfg_now(), {23'd0, 3'd6, 3'd1, 3'd2});
  endtask

  task automatic t_clocks_late();
    clk_en = 2'b00;
    do_reset(3'd2, 3'd3, 3'd0);
    step(WIN + 1);
    chk("R10 recapture after reset", cfg_now(), {23'd0, 3'd2, 3'd3, 3'd0});
    step(200);
    chk("R6 stays unlocked without clocks", unlock, 1);
    clk_en = 2'b11;
    step((SW - 1) * TMO - 6);
    chk("R6 not locked before stable windows", unlock, 1);
    step(2 * TMO + 12);
    chk("R6 locked once clocks stable", unlock, 0);
    chk("R9 mute released", mute, 0);
  endtask

  initial begin
    t_reset_and_capture();
    t_frozen();
    t_restart();
    t_loss_recover();
    t_clocks_late();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule